// File: doc/BRIEF.md
# Processor Bus Request-Phase Receiver

This block sits on the receive side of a shared processor bus and turns its two-part request phase into one decoded transaction record for the core. The bus lines are active low. After the address strobe is seen, the address and request lines carry the transaction address in the first sub-phase. In the second sub-phase the same lines carry transaction-type information. Two strobe lanes each cover a separate group of lines. The block samples every wire on the core clock and detects the edges of each strobe. The asserting edge of a strobe latches that lane's first-sub-phase payload, and the releasing edge latches its second-sub-phase payload.

A request is complete once both lanes have seen both edges. The block then writes the assembled record into a two-entry buffer, and the core drains that buffer with a valid/take handshake. If address-bit-20 masking is requested while the real-mode flag is set, bit 20 of the stored address is cleared. On the cycle in which reset is released, the block latches a masked subset of the address lines as configuration straps. A registered copy of the block-next-request line tells the local issue logic to hold off.

Top module: `fsb_req_capture`

## Requirements
- R1: Every bus input is active low. A wire driven to 0 appears as 1 in the record fields, and a wire driven to 1 appears as 0.
- R2: `rec_addr` and `rec_req_a` hold the values latched in the first sub-phase. `rec_attr` and `rec_req_b` hold the values latched in the second sub-phase.
- R3: An address strobe that arrives while both buffer entries are full is dropped and sets `overflow`. Only reset clears `overflow`.
- R4: Strobe lane 0 (`stb_n[0]`) latches `bus_req_n` and `bus_a_n[16:3]`. Strobe lane 1 (`stb_n[1]`) latches `bus_a_n[35:17]`. The two lanes may switch on different cycles.
- R5: For each lane, the falling wire edge (strobe asserted) latches the first sub-phase and the rising wire edge latches the second. No record appears until both lanes have seen their rising edge.
- R6: On the first clock with `rst` low after reset, `cfg_straps` takes the asserted address lines ANDed with `STRAP_MASK`. It then holds that value until the next reset release.
- R7: When `a20m_n` is 0 and `real_mode` is 1 at completion, bit 20 of `rec_addr` is 0. Otherwise bit 20 is passed through unchanged.
- R8: `issue_hold` equals the inverse of `bnr_n` as sampled on the previous clock edge.
- R9: The buffer holds up to two records in arrival order. While `rec_valid` is 1 and `rec_take` is 0, the output record does not change. A cycle with `rec_take` high removes the head record.
- R10: `rec_new` is high for exactly one cycle per stored record, on the cycle in which the record becomes visible.
- R11: While reset is held and right after it is released, `rec_valid`, `rec_new` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_a_n | input | 33 | Address lines [35:3], active low |
| bus_req_n | input | 5 | Request lines, active low |
| ads_n | input | 1 | Address strobe, active low |
| stb_n | input | 2 | Lane strobes, active low |
| bnr_n | input | 1 | Block-next-request, active low |
| a20m_n | input | 1 | Address-bit-20 mask, active low |
| real_mode | input | 1 | Real-mode flag that enables the mask |
| rec_take | input | 1 | Core removes the head record |
| rec_valid | output | 1 | Head record present |
| rec_addr | output | 33 | Address [35:3] from the first sub-phase |
| rec_req_a | output | 5 | Request lines from the first sub-phase |
| rec_req_b | output | 5 | Request lines from the second sub-phase |
| rec_attr | output | 33 | Address lines from the second sub-phase |
| rec_new | output | 1 | One-cycle pulse when a record is stored |
| overflow | output | 1 | Sticky: a request was dropped |
| issue_hold | output | 1 | Local issuer must not start a request |
| cfg_straps | output | 33 | Configuration straps latched at reset release |

## Verification
The hardest situation to reach is a request whose two strobe lanes move on different cycles. In that case one lane has already latched its second-sub-phase payload while the shared lines still carry first-sub-phase data for the other lane. The stimulus draws a separate assertion cycle and hold length for each lane, and drives each line group from its own lane's schedule. It also checks, on the cycle before the last release edge is sampled, that no record has appeared yet. Overflow is reached by leaving two records unread and then starting a third request.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
    localparam int ADDR_HI = 35;
    localparam int ADDR_LO = 3;
    localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
    localparam int REQ_W   = 5;
    localparam int SPLIT   = 16;
    localparam int A20_BIT = 20;
    localparam int LANES   = 2;
    localparam int L0_W    = REQ_W + SPLIT - ADDR_LO + 1;
    localparam int L1_W    = ADDR_HI - SPLIT;
    localparam int LANE_W  = (L0_W > L1_W) ? L0_W : L1_W;

    typedef logic [ADDR_HI:ADDR_LO] addr_t;
    typedef logic [REQ_W-1:0]       req_t;

    typedef struct packed {
        addr_t addr;
        req_t  req_a;
        req_t  req_b;
        addr_t attr;
    } rec_t;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_WAIT_ASSERT,
        LN_WAIT_RELEASE,
        LN_DONE
    } lane_st_e;

    typedef enum logic {
        RQ_IDLE,
        RQ_CAPT
    } req_st_e;

    function automatic addr_t apply_a20(input addr_t a, input logic en);
        addr_t r;
        r = a;
        if (en) begin
            r[A20_BIT] = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/fsb_strobe_lane.sv
module fsb_strobe_lane
    import fsb_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         stb_act,
    input  logic [W-1:0] din,
    output logic [W-1:0] ph1,
    output logic [W-1:0] ph2,
    output logic         done
);
    lane_st_e st;
    logic     stb_prev;
    logic     edge_on;
    logic     edge_off;

    assign edge_on  = stb_act & ~stb_prev;
    assign edge_off = ~stb_act & stb_prev;
    assign done     = (st == LN_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b0;
            st       <= LN_IDLE;
            ph1      <= '0;
            ph2      <= '0;
        end else begin
            stb_prev <= stb_act;
            if (clr) begin
                st <= LN_WAIT_ASSERT;
            end else begin
                case (st)
                    LN_WAIT_ASSERT: begin
                        if (edge_on) begin
                            ph1 <= din;
                            st  <= LN_WAIT_RELEASE;
                        end
                    end
                    LN_WAIT_RELEASE: begin
                        if (edge_off) begin
                            ph2 <= din;
                            st  <= LN_DONE;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end
endmodule

// File: rtl/fsb_rec_fifo.sv
module fsb_rec_fifo
    import fsb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  rec_t wdata,
    input  logic rd,
    output rec_t rdata,
    output logic valid,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rec_t          mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_wr;
    logic          do_rd;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid = (cnt != '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = wr & ~full;
    assign do_rd = rd & valid;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                mem[wp] <= wdata;
                wp      <= nxt(wp);
            end
            if (do_rd) begin
                rp <= nxt(rp);
            end
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/fsb_req_capture.sv
module fsb_req_capture
    import fsb_pkg::*;
#(
    parameter addr_t STRAP_MASK = 33'h0_003F_F0FF,
    parameter int    DEPTH      = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_HI:ADDR_LO] bus_a_n,
    input  logic [REQ_W-1:0]       bus_req_n,
    input  logic                   ads_n,
    input  logic [LANES-1:0]       stb_n,
    input  logic                   bnr_n,
    input  logic                   a20m_n,
    input  logic                   real_mode,
    input  logic                   rec_take,
    output logic                   rec_valid,
    output logic [ADDR_HI:ADDR_LO] rec_addr,
    output logic [REQ_W-1:0]       rec_req_a,
    output logic [REQ_W-1:0]       rec_req_b,
    output logic [ADDR_HI:ADDR_LO] rec_attr,
    output logic                   rec_new,
    output logic                   overflow,
    output logic                   issue_hold,
    output logic [ADDR_HI:ADDR_LO] cfg_straps
);
    // input sampling, active-low wires turned active-high
    addr_t            a_q;
    req_t             req_q;
    logic             ads_q;
    logic [LANES-1:0] stb_q;
    logic             bnr_q;
    logic             a20_q;
    logic             real_q;
    logic             rst_q;

    always_ff @(posedge clk) begin
        a_q    <= ~bus_a_n;
        req_q  <= ~bus_req_n;
        bnr_q  <= ~bnr_n;
        a20_q  <= ~a20m_n;
        real_q <= real_mode;
        rst_q  <= rst;
        if (rst) begin
            ads_q <= 1'b0;
            stb_q <= '0;
        end else begin
            ads_q <= ~ads_n;
            stb_q <= ~stb_n;
        end
    end

    // request sequencing
    req_st_e st;
    logic    fifo_full;
    logic    start;
    logic    drop;
    logic    push;
    rec_t    wr_rec;
    rec_t    rd_rec;

    logic [LANE_W-1:0] lane_in   [LANES];
    logic [LANE_W-1:0] lane_p1   [LANES];
    logic [LANE_W-1:0] lane_p2   [LANES];
    logic [LANES-1:0]  lane_done;

    assign lane_in[0] = LANE_W'({req_q, a_q[SPLIT:ADDR_LO]});
    assign lane_in[1] = LANE_W'(a_q[ADDR_HI:SPLIT+1]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fsb_strobe_lane #(.W(LANE_W)) i_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (start),
            .stb_act (stb_q[g]),
            .din     (lane_in[g]),
            .ph1     (lane_p1[g]),
            .ph2     (lane_p2[g]),
            .done    (lane_done[g])
        );
    end

    assign start = (st == RQ_IDLE) & ads_q & ~fifo_full;
    assign drop  = (st == RQ_IDLE) & ads_q & fifo_full;
    assign push  = (st == RQ_CAPT) & (&lane_done);

    always_comb begin
        wr_rec       = '0;
        wr_rec.addr  = apply_a20({lane_p1[1][L1_W-1:0], lane_p1[0][L0_W-REQ_W-1:0]},
                                 a20_q & real_q);
        wr_rec.req_a = lane_p1[0][L0_W-1 -: REQ_W];
        wr_rec.attr  = {lane_p2[1][L1_W-1:0], lane_p2[0][L0_W-REQ_W-1:0]};
        wr_rec.req_b = lane_p2[0][L0_W-1 -: REQ_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RQ_IDLE;
            rec_new  <= 1'b0;
            overflow <= 1'b0;
        end else begin
            rec_new <= push;
            if (drop) begin
                overflow <= 1'b1;
            end
            case (st)
                RQ_IDLE: if (start) st <= RQ_CAPT;
                RQ_CAPT: if (push)  st <= RQ_IDLE;
                default: st <= RQ_IDLE;
            endcase
        end
    end

    fsb_rec_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (push),
        .wdata (wr_rec),
        .rd    (rec_take),
        .rdata (rd_rec),
        .valid (rec_valid),
        .full  (fifo_full)
    );

    assign rec_addr  = rd_rec.addr;
    assign rec_req_a = rd_rec.req_a;
    assign rec_req_b = rd_rec.req_b;
    assign rec_attr  = rd_rec.attr;

    // configuration straps, latched once per reset release
    addr_t straps;
    always_ff @(posedge clk) begin
        if (rst_q & ~rst) begin
            straps <= a_q & STRAP_MASK;
        end
    end
    assign cfg_straps = straps;

    assign issue_hold = bnr_q;
endmodule

// File: rtl/fsb_req_capture_chk.sv
module fsb_req_capture_chk
    import fsb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bnr_n,
    input logic  rec_take,
    input logic  rec_valid,
    input addr_t rec_addr,
    input addr_t rec_attr,
    input logic  rec_new,
    input logic  overflow,
    input logic  issue_hold,
    input addr_t cfg_straps
);
    assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_overflow_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(rec_valid));

    assert_straps_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> $stable(cfg_straps));

    assert_hold_follows_bnr_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (issue_hold == !$past(bnr_n)));

    assert_head_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_take) |=> (rec_valid && $stable(rec_addr) && $stable(rec_attr)));

    assert_new_is_visible_R9: assert property (@(posedge clk) disable iff (rst)
        rec_new |-> rec_valid);

    assert_new_single_R10: assert property (@(posedge clk) disable iff (rst)
        rec_new |=> !rec_new);
endmodule

bind fsb_req_capture fsb_req_capture_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .bnr_n      (bnr_n),
    .rec_take   (rec_take),
    .rec_valid  (rec_valid),
    .rec_addr   (rec_addr),
    .rec_attr   (rec_attr),
    .rec_new    (rec_new),
    .overflow   (overflow),
    .issue_hold (issue_hold),
    .cfg_straps (cfg_straps)
);

// File: tb/test_fsb_req_capture.sv
module test_fsb_req_capture;
    import fsb_pkg::*;

    localparam addr_t MASK      = 33'h0_003F_F0FF;
    localparam addr_t STRAP_PAT = 33'h1_2345_6789;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    addr_t      bus_a_n;
    req_t       bus_req_n;
    logic       ads_n;
    logic [1:0] stb_n;
    logic       bnr_n;
    logic       a20m_n;
    logic       real_mode;
    logic       rec_take;
    logic       rec_valid;
    addr_t      rec_addr;
    req_t       rec_req_a;
    req_t       rec_req_b;
    addr_t      rec_attr;
    logic       rec_new;
    logic       overflow;
    logic       issue_hold;
    addr_t      cfg_straps;

    fsb_req_capture #(.STRAP_MASK(MASK), .DEPTH(2)) i_fsb_req_capture (
        .clk        (clk),
        .rst        (rst),
        .bus_a_n    (bus_a_n),
        .bus_req_n  (bus_req_n),
        .ads_n      (ads_n),
        .stb_n      (stb_n),
        .bnr_n      (bnr_n),
        .a20m_n     (a20m_n),
        .real_mode  (real_mode),
        .rec_take   (rec_take),
        .rec_valid  (rec_valid),
        .rec_addr   (rec_addr),
        .rec_req_a  (rec_req_a),
        .rec_req_b  (rec_req_b),
        .rec_attr   (rec_attr),
        .rec_new    (rec_new),
        .overflow   (overflow),
        .issue_hold (issue_hold),
        .cfg_straps (cfg_straps)
    );

    int   checks   = 0;
    int   failures = 0;
    int   new_cnt  = 0;
    int   accepted = 0;
    bit   finished = 0;
    rec_t exq[$];

    always @(negedge clk) begin
        if (!rst && rec_new) new_cnt++;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic addr_t expect_addr(input addr_t a, input logic mask_on);
        addr_t r;
        r = a;
        if (mask_on) r[A20_BIT] = 1'b0;
        return r;
    endfunction

    task automatic issue(input addr_t p1a, input req_t p1r, input addr_t p2a,
                         input req_t p2r, input int f0, input int h0,
                         input int f1, input int h1);
        bit   accept;
        int   last;
        rec_t e;
        accept = (exq.size() < 2);
        last   = (f0 + h0 > f1 + h1) ? f0 + h0 : f1 + h1;
        @(negedge clk);
        ads_n     = 1'b0;
        bus_a_n   = ~p1a;
        bus_req_n = ~p1r;
        for (int t = 1; t <= last + 4; t++) begin
            @(negedge clk);
            if (t == last && accept && exq.size() == 0)
                chk(rec_valid == 1'b0, "R5", "record before last release",
                    64'(rec_valid), 64'd0);
            ads_n = 1'b1;
            if (t < f0 + h0) begin
                bus_req_n            = ~p1r;
                bus_a_n[SPLIT:ADDR_LO] = ~p1a[SPLIT:ADDR_LO];
            end else begin
                bus_req_n            = ~p2r;
                bus_a_n[SPLIT:ADDR_LO] = ~p2a[SPLIT:ADDR_LO];
            end
            if (t < f1 + h1) bus_a_n[ADDR_HI:SPLIT+1] = ~p1a[ADDR_HI:SPLIT+1];
            else             bus_a_n[ADDR_HI:SPLIT+1] = ~p2a[ADDR_HI:SPLIT+1];
            stb_n[0] = !(t >= f0 && t < f0 + h0);
            stb_n[1] = !(t >= f1 && t < f1 + h1);
        end
        if (accept) begin
            e.addr  = expect_addr(p1a, !a20m_n && real_mode);
            e.req_a = p1r;
            e.attr  = p2a;
            e.req_b = p2r;
            exq.push_back(e);
            accepted++;
            chk(rec_valid == 1'b1, "R9", "valid after completion", 64'(rec_valid), 64'd1);
        end else begin
            chk(overflow == 1'b1, "R3", "overflow on full", 64'(overflow), 64'd1);
        end
    endtask

    task automatic pop();
        rec_t e;
        @(negedge clk);
        if (exq.size() == 0) begin
            chk(rec_valid == 1'b0, "R3", "no extra record", 64'(rec_valid), 64'd0);
        end else begin
            e = exq.pop_front();
            chk(rec_valid == 1'b1, "R9", "head present", 64'(rec_valid), 64'd1);
            chk(rec_addr == e.addr, "R1/R7", "address", 64'(rec_addr), 64'(e.addr));
            chk(rec_req_a == e.req_a, "R2", "req sub-phase 1", 64'(rec_req_a), 64'(e.req_a));
            chk(rec_attr == e.attr, "R2", "attr sub-phase 2", 64'(rec_attr), 64'(e.attr));
            chk(rec_req_b == e.req_b, "R4", "req sub-phase 2", 64'(rec_req_b), 64'(e.req_b));
            rec_take = 1'b1;
            @(negedge clk);
            rec_take = 1'b0;
        end
    endtask

    function automatic addr_t rnd_addr();
        return addr_t'({$urandom(), $urandom()});
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog all act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst       = 1'b1;
        bus_a_n   = ~STRAP_PAT;
        bus_req_n = '1;
        ads_n     = 1'b1;
        stb_n     = 2'b11;
        bnr_n     = 1'b1;
        a20m_n    = 1'b1;
        real_mode = 1'b0;
        rec_take  = 1'b0;
        repeat (5) @(negedge clk);
        chk(rec_valid == 1'b0 && overflow == 1'b0 && rec_new == 1'b0, "R11",
            "outputs in reset", 64'({rec_valid, overflow, rec_new}), 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_straps == (STRAP_PAT & MASK), "R6", "straps",
            64'(cfg_straps), 64'(STRAP_PAT & MASK));
        chk(rec_valid == 1'b0 && overflow == 1'b0 && rec_new == 1'b0, "R11",
            "outputs after reset", 64'({rec_valid, overflow, rec_new}), 64'd0);
        bus_a_n = '1;

        // R7: mask honoured only in real mode
        a20m_n = 1'b0; real_mode = 1'b1;
        issue(33'h1_0010_0008, 5'h15, 33'h0_0ABC_0000, 5'h0A, 1, 1, 1, 1);
        pop();
        a20m_n = 1'b0; real_mode = 1'b0;
        issue(33'h0_8010_0010, 5'h03, 33'h1_FFFF_FFFF, 5'h1C, 2, 2, 1, 3);
        pop();
        a20m_n = 1'b1; real_mode = 1'b1;
        issue(33'h0_0010_0000, 5'h1F, 33'h0_0000_0001, 5'h00, 1, 2, 2, 1);
        pop();

        // R4/R5: strongly skewed lanes, both orders
        issue(rnd_addr(), 5'h11, rnd_addr(), 5'h0E, 3, 3, 1, 1);
        pop();
        issue(rnd_addr(), 5'h07, rnd_addr(), 5'h18, 1, 1, 3, 3);
        pop();

        // R8: stall input
        @(negedge clk); bnr_n = 1'b0;
        @(negedge clk);
        chk(issue_hold == 1'b1, "R8", "hold asserted", 64'(issue_hold), 64'd1);
        bnr_n = 1'b1;
        @(negedge clk);
        chk(issue_hold == 1'b0, "R8", "hold released", 64'(issue_hold), 64'd0);

        // R3: fill both entries, third request dropped
        issue(rnd_addr(), 5'h01, rnd_addr(), 5'h02, 1, 1, 1, 2);
        issue(rnd_addr(), 5'h03, rnd_addr(), 5'h04, 2, 1, 1, 1);
        chk(overflow == 1'b0, "R3", "no overflow at two", 64'(overflow), 64'd0);
        issue(rnd_addr(), 5'h05, rnd_addr(), 5'h06, 1, 1, 1, 1);
        pop();
        pop();
        pop();
        chk(overflow == 1'b1, "R3", "overflow sticky", 64'(overflow), 64'd1);

        // random phase
        for (int i = 0; i < 40; i++) begin
            a20m_n    = $urandom_range(0, 1) != 0;
            real_mode = $urandom_range(0, 1) != 0;
            bnr_n     = $urandom_range(0, 1) != 0;
            issue(rnd_addr(), req_t'($urandom()), rnd_addr(), req_t'($urandom()),
                  $urandom_range(1, 3), $urandom_range(1, 3),
                  $urandom_range(1, 3), $urandom_range(1, 3));
            chk(issue_hold == !bnr_n, "R8", "hold random", 64'(issue_hold), 64'(!bnr_n));
            if ($urandom_range(0, 9) < 7) pop();
        end
        while (exq.size() > 0) pop();
        pop();

        chk(new_cnt == accepted, "R10", "one pulse per record", 64'(new_cnt), 64'(accepted));
        chk(cfg_straps == (STRAP_PAT & MASK), "R6", "straps unchanged",
            64'(cfg_straps), 64'(STRAP_PAT & MASK));

        finished = 1;
        summary();
        $finish;
    end
endmodule